// File: doc/BRIEF.md
# Memory-Mapped Character FIFO Port

A console-style peripheral that moves bytes between a processor and a host. Characters coming from the host arrive on a valid/ready byte stream and wait in a receive FIFO; characters written by the processor wait in a transmit FIFO and leave on a second valid/ready byte stream. The processor sees two 32-bit words on a simple word-addressed slave port. Word 0 is the character word. Reading it pops one received character and also returns a valid bit and the number of characters still queued. Writing it queues one character for the host. Word 1 is the control word. It holds two interrupt enables, the two interrupt pending flags, a sticky activity flag and the free space left in the transmit FIFO.

Both host streams follow the usual valid/ready rules. A byte moves on a clock edge where valid and ready are both high. The receive side drops `rx_ready` while its FIFO is full, and the host must then hold the byte and keep valid asserted. The transmit side keeps `tx_valid` high and `tx_data` unchanged until the host takes the byte with `tx_ready`. The bus side has no back-pressure. A write to a full transmit FIFO is lost. A read always completes, and its data appears one cycle after the request.

The FIFO depth (a power of two, at most 64) and both interrupt thresholds are parameters. A single level-sensitive interrupt output combines the two enabled pending flags.

Top module: `char_fifo_port`

## Requirements
- R1: After reset the receive FIFO is empty (`rx_ready`=1), the transmit FIFO is empty (`tx_valid`=0), both enables and the activity flag are 0, and `irq` is 0.
- R2: A host byte is accepted on an edge where `rx_valid` and `rx_ready` are both 1. `rx_ready` is 0 exactly when DEPTH bytes are held.
- R3: A bus read of word 0 pops the oldest received byte. One cycle later `rd_data` holds the byte in bits 7:0, a 1 in bit 15, zeros in bits 14:8, and in bits 31:16 the occupancy at the request minus one. A byte that arrives in the same cycle is not counted in that field.
- R4: A read of word 0 while the receive FIFO is empty returns all zeros and changes no state.
- R5: A bus write of word 0 queues `wr_data[7:0]` for transmission. When DEPTH bytes are already queued, the byte is dropped and the queued bytes are unchanged.
- R6: `tx_valid` is 1 whenever a byte is queued. Bytes leave in write order, and `tx_data` holds steady while `tx_valid` is 1 and `tx_ready` is 0.
- R7: A read of word 1 returns the read enable in bit 0, the write enable in bit 1, read pending in bit 8, write pending in bit 9, the activity flag in bit 10, and DEPTH minus the transmit occupancy in bits 31:16. All other bits are 0.
- R8: A write of word 1 loads bits 0 and 1 into the two enables. Writing 1 in bit 10 clears the activity flag, and writing 0 there leaves it unchanged. The pending bits and the free field ignore writes.
- R9: The activity flag sets on any host-stream transfer in either direction. If a transfer and a clear fall in the same cycle, the flag ends up set.
- R10: Read pending is 1 while the receive occupancy is at least RX_THRESH.
- R11: Write pending is 1 while the transmit occupancy is below TX_THRESH.
- R12: `irq` = (read enable AND read pending) OR (write enable AND write pending), updated in the cycle after the change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Bus request strobe, one cycle per access |
| wr | input | 1 | 1 = write, 0 = read |
| word_sel | input | 1 | 0 = character word, 1 = control word |
| wr_data | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| rx_valid | input | 1 | Host byte valid |
| rx_ready | output | 1 | Receive FIFO can take a byte |
| rx_data | input | 8 | Host byte |
| tx_valid | output | 1 | Byte available for the host |
| tx_ready | input | 1 | Host takes the byte |
| tx_data | output | 8 | Byte to the host |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DEPTH=4, RX_THRESH=2 and TX_THRESH=2. With these values every occupancy from empty to full, and one attempt past full, can be swept on both FIFOs. Each pending flag crosses its threshold within those sweeps. All four enable combinations are then applied against every pairing of pending and not-pending states. The count field, the free field and the dropped writes can therefore be checked at every value they can take.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
  // bit positions inside the two bus words
  localparam int unsigned CHAR_LSB  = 0;
  localparam int unsigned RD_OK_BIT = 15;
  localparam int unsigned CNT_LSB   = 16;
  localparam int unsigned EN_RD_BIT = 0;
  localparam int unsigned EN_WR_BIT = 1;
  localparam int unsigned PD_RD_BIT = 8;
  localparam int unsigned PD_WR_BIT = 9;
  localparam int unsigned ACT_BIT   = 10;

  typedef enum logic {
    WORD_CHAR = 1'b0,
    WORD_CTRL = 1'b1
  } word_e;
endpackage

// File: rtl/char_fifo.sv
module char_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic             do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/cfp_ctrl.sv
module cfp_ctrl #(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned RX_THRESH = 1,
  parameter int unsigned TX_THRESH = 1,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic          en_rd_in,
  input  logic          en_wr_in,
  input  logic          act_clr,
  input  logic          host_evt,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  output logic          en_rd,
  output logic          en_wr,
  output logic          act,
  output logic          pend_rd,
  output logic          pend_wr,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_rd <= 1'b0;
      en_wr <= 1'b0;
      act   <= 1'b0;
    end else begin
      if (ctl_wr) begin
        en_rd <= en_rd_in;
        en_wr <= en_wr_in;
      end
      // a transfer in the same cycle beats a clear
      if (host_evt)                act <= 1'b1;
      else if (ctl_wr && act_clr)  act <= 1'b0;
    end
  end

  assign pend_rd = (rx_count >= CW'(RX_THRESH));
  assign pend_wr = (tx_count <  CW'(TX_THRESH));
  assign irq     = (en_rd && pend_rd) || (en_wr && pend_wr);
endmodule

// File: rtl/char_fifo_port.sv
module char_fifo_port
  import cfp_pkg::*;
#(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned RX_THRESH = 1,
  parameter int unsigned TX_THRESH = 1,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        wr,
  input  logic        word_sel,
  input  logic [31:0] wr_data,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data
  ,output logic       irq
);
  logic [7:0]    rx_head;
  logic [CW-1:0] rx_count, tx_count;
  logic          rx_full, rx_empty, tx_full, tx_empty;
  logic          rd_char, wr_char, wr_ctrl, rd_ctrl;
  logic          rx_fire, tx_fire;
  logic          en_rd, en_wr, act_flag, pend_rd, pend_wr;
  logic [CW-1:0] tx_free, rx_left;

  assign rd_char = req && !wr && (word_sel == WORD_CHAR);
  assign rd_ctrl = req && !wr && (word_sel == WORD_CTRL);
  assign wr_char = req &&  wr && (word_sel == WORD_CHAR);
  assign wr_ctrl = req &&  wr && (word_sel == WORD_CTRL);

  assign rx_ready = !rx_full;
  assign rx_fire  = rx_valid && rx_ready;
  assign tx_valid = !tx_empty;
  assign tx_fire  = tx_valid && tx_ready;

  char_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_valid), .din(rx_data),
    .pop(rd_char), .dout(rx_head),
    .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  char_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(wr_char), .din(wr_data[7:0]),
    .pop(tx_ready), .dout(tx_data),
    .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  cfp_ctrl #(.DEPTH(DEPTH), .RX_THRESH(RX_THRESH), .TX_THRESH(TX_THRESH)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(wr_ctrl),
    .en_rd_in(wr_data[EN_RD_BIT]), .en_wr_in(wr_data[EN_WR_BIT]),
    .act_clr(wr_data[ACT_BIT]),
    .host_evt(rx_fire || tx_fire),
    .rx_count(rx_count), .tx_count(tx_count),
    .en_rd(en_rd), .en_wr(en_wr), .act(act_flag),
    .pend_rd(pend_rd), .pend_wr(pend_wr), .irq(irq)
  );

  assign tx_free = CW'(DEPTH) - tx_count;
  assign rx_left = rx_empty ? '0 : rx_count - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_char || rd_ctrl;
      if (rd_char) begin
        rd_data <= '0;
        if (!rx_empty) begin
          rd_data[CHAR_LSB +: 8]  <= rx_head;
          rd_data[RD_OK_BIT]      <= 1'b1;
          rd_data[CNT_LSB +: 16]  <= 16'(rx_left);
        end
      end else if (rd_ctrl) begin
        rd_data <= '0;
        rd_data[EN_RD_BIT]     <= en_rd;
        rd_data[EN_WR_BIT]     <= en_wr;
        rd_data[PD_RD_BIT]     <= pend_rd;
        rd_data[PD_WR_BIT]     <= pend_wr;
        rd_data[ACT_BIT]       <= act_flag;
        rd_data[CNT_LSB +: 16] <= 16'(tx_free);
      end
    end
  end
endmodule

// File: rtl/cfp_checker.sv
module cfp_checker #(
  parameter int unsigned DEPTH = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic        wr,
  input logic        word_sel,
  input logic [31:0] wr_data,
  input logic        rd_valid,
  input logic [31:0] rd_data,
  input logic        rx_valid,
  input logic        rx_ready,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        irq,
  input logic        act_flag
);
  logic [7:0]  occ;
  logic        m_en_rd, m_en_wr;
  logic        last_char_rd, exp_ok;
  logic [15:0] exp_left;
  logic        rx_fire, rd_char;

  assign rx_fire = rx_valid && rx_ready;
  assign rd_char = req && !wr && !word_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ          <= '0;
      m_en_rd      <= 1'b0;
      m_en_wr      <= 1'b0;
      last_char_rd <= 1'b0;
      exp_ok       <= 1'b0;
      exp_left     <= '0;
    end else begin
      occ <= occ + 8'(rx_fire) - 8'(rd_char && occ != 0);
      if (req && wr && word_sel) begin
        m_en_rd <= wr_data[0];
        m_en_wr <= wr_data[1];
      end
      last_char_rd <= rd_char;
      exp_ok       <= (occ != 0);
      exp_left     <= (occ != 0) ? 16'(occ - 8'd1) : 16'd0;
    end
  end

  a_r2_ready_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready == (occ != 8'(DEPTH)));

  a_r3_valid_bit: assert property (@(posedge clk) disable iff (!rst_n)
    last_char_rd |-> (rd_valid && rd_data[15] == exp_ok));

  a_r3_left_count: assert property (@(posedge clk) disable iff (!rst_n)
    last_char_rd |-> rd_data[31:16] == exp_left);

  a_r4_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (last_char_rd && !exp_ok) |-> rd_data == 32'd0);

  a_r6_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  a_r9_act_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fire || (tx_valid && tx_ready)) |=> act_flag);

  a_r12_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_en_rd && !m_en_wr) |-> !irq);
endmodule

bind char_fifo_port cfp_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .word_sel(word_sel),
  .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .irq(irq), .act_flag(act_flag)
);

// File: tb/sim_char_fifo_port.sv
module sim_char_fifo_port;
  localparam int D  = 4;
  localparam int RT = 2;
  localparam int TT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 0, wr = 0, word_sel = 0;
  logic [31:0] wr_data = '0;
  logic rd_valid;
  logic [31:0] rd_data;
  logic rx_valid = 0, rx_ready;
  logic [7:0] rx_data = '0;
  logic tx_valid, tx_ready = 0;
  logic [7:0] tx_data;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  char_fifo_port #(.DEPTH(D), .RX_THRESH(RT), .TX_THRESH(TT)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .word_sel(word_sel),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic w, input logic [31:0] d);
    @(negedge clk);
    req = 1; wr = 1; word_sel = w; wr_data = d;
    @(negedge clk);
    req = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic w, output logic [31:0] d);
    @(negedge clk);
    req = 1; wr = 0; word_sel = w;
    @(negedge clk);
    req = 0;
    d = rd_data;
  endtask

  task automatic host_push(input logic [7:0] b, output logic rdy);
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    #0 rdy = rx_ready;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic host_take();
    @(negedge clk);
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
  endtask

  function automatic logic [31:0] ctl_word(int en, int rxn, int txn, bit a);
    logic [31:0] v;
    v = 32'(en & 3);
    v[8]  = (rxn >= RT);
    v[9]  = (txn < TT);
    v[10] = a;
    v[31:16] = 16'(D - txn);
    return v;
  endfunction

  function automatic logic [7:0] pat(int n, int i);
    return 8'(8'h31 + n * 16 + i * 3);
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    logic r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rx_ready", 32'(rx_ready), 1);
    chk("R1 tx_valid", 32'(tx_valid), 0);
    chk("R1 irq", 32'(irq), 0);
    bus_rd(1'b1, d);
    chk("R1 control word", d, ctl_word(0, 0, 0, 0));

    // R2 R3 R4 R10: receive sweep from empty to one past full
    for (int n = 0; n <= D + 1; n++) begin
      int acc;
      acc = (n < D) ? n : D;
      for (int i = 0; i < n; i++) begin
        host_push(pat(n, i), r);
        chk("R2 rx_ready before push", 32'(r), 32'(i < D));
      end
      bus_rd(1'b1, d);
      chk("R10 read pending", 32'(d[8]), 32'(acc >= RT));
      for (int j = 0; j <= acc; j++) begin
        bus_rd(1'b0, d);
        if (j < acc)
          chk("R3 char word", d, {16'(acc - 1 - j), 1'b1, 7'b0, pat(n, j)});
        else
          chk("R4 empty read", d, 32'd0);
      end
      bus_rd(1'b1, d);
      chk("R4 state after empty read", 32'(d[8]), 0);
      bus_wr(1'b1, 32'h400);
    end

    // R5 R6 R7 R11: transmit sweep
    for (int k = 0; k <= D + 1; k++) begin
      int q;
      q = (k < D) ? k : D;
      for (int i = 0; i < k; i++) bus_wr(1'b0, {24'hABCDEF, pat(k, i)});
      bus_rd(1'b1, d);
      chk("R7 control free field", d, ctl_word(0, 0, q, 0));
      chk("R11 write pending", 32'(d[9]), 32'(q < TT));
      chk("R6 tx_valid", 32'(tx_valid), 32'(q > 0));
      for (int j = 0; j < q; j++) begin
        @(negedge clk);
        chk("R5 R6 tx order", {23'b0, tx_valid, tx_data}, {23'b0, 1'b1, pat(k, j)});
        host_take();
      end
      @(negedge clk);
      chk("R6 drained", 32'(tx_valid), 0);
      bus_wr(1'b1, 32'h400);
    end

    // R8 R9 activity flag
    bus_rd(1'b1, d);
    chk("R8 activity cleared", 32'(d[10]), 0);
    host_push(8'h55, r);
    bus_rd(1'b1, d);
    chk("R9 set by rx", 32'(d[10]), 1);
    bus_wr(1'b1, 32'hFFFF_FBFC);
    bus_rd(1'b1, d);
    chk("R8 write 0 keeps flag, ro bits ignored", d, ctl_word(0, 1, 0, 1));
    bus_wr(1'b1, 32'h400);
    bus_rd(1'b1, d);
    chk("R8 write 1 clears", 32'(d[10]), 0);
    bus_rd(1'b0, d);
    bus_wr(1'b1, 32'h400);
    @(negedge clk);
    rx_valid = 1; rx_data = 8'h66;
    req = 1; wr = 1; word_sel = 1; wr_data = 32'h400;
    @(negedge clk);
    rx_valid = 0; req = 0; wr = 0;
    bus_rd(1'b1, d);
    chk("R9 set wins over clear", 32'(d[10]), 1);
    bus_rd(1'b0, d);
    bus_wr(1'b1, 32'h400);
    bus_wr(1'b0, 32'h77);
    host_take();
    bus_rd(1'b1, d);
    chk("R9 set by tx", 32'(d[10]), 1);

    // R12 interrupt sweep
    for (int rs = 0; rs < 2; rs++) begin
      for (int ts = 0; ts < 2; ts++) begin
        int rxn, txn;
        rxn = rs * 2;
        txn = ts * 3;
        for (int i = 0; i < rxn; i++) host_push(8'(i), r);
        for (int i = 0; i < txn; i++) bus_wr(1'b0, 32'(i));
        for (int en = 0; en < 4; en++) begin
          bus_wr(1'b1, 32'(en));
          chk("R12 irq", 32'(irq),
              32'(((en & 1) != 0 && rxn >= RT) || ((en & 2) != 0 && txn < TT)));
          bus_rd(1'b1, d);
          chk("R8 enables readback", 32'(d[1:0]), 32'(en));
        end
        bus_wr(1'b1, 32'h400);
        for (int i = 0; i < rxn; i++) bus_rd(1'b0, d);
        for (int i = 0; i < txn; i++) host_take();
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule